// File: doc/BRIEF.md
# Flow Control Credit Packet Receiver

This block sits on the receive side of a link layer. It takes in 4-byte link management packets whose integrity check the upstream logic has already done. It keeps the receive-side record of the credit limits that the link partner advertises. There are three traffic classes: posted, non-posted and completion. For each class the block holds an 8-bit header credit limit and a 12-bit data credit limit.

A zero credit in an initialization packet means the partner grants unlimited credit of that kind. The block keeps that fact as an infinite flag for each class and each credit kind. A later update packet that tries to set a finite value in place of an infinite one is a protocol violation. The block rejects that update and reports it on a one-cycle error pulse.

The block also follows the two-phase initialization handshake. Phase one ends once a first-phase initialization packet has been seen for every class. After that, any second-phase initialization packet or update packet ends phase two.

The upstream logic presents one packet per cycle with `pkt_vld`, together with a CRC-good flag and a bad-end-marker flag. All outputs are registered and change on the clock edge that samples the packet.

Top module: `fc_credit_rx`

## Requirements
- R1: The packet type is `pkt_b0[7:4]`. Its low two bits select the class: 0 is posted, 1 is non-posted, 2 is completion. Its high two bits select the kind: 01 is init phase 1, 11 is init phase 2, 10 is update. Class `c` is reported in `hdr_lim[8c+7:8c]` and `dat_lim[12c+11:12c]`.
- R2: The header credit is `{pkt_b1[5:0], pkt_b2[7:6]}`. Bits `pkt_b0[3:0]`, `pkt_b1[7:6]` and `pkt_b2[5:4]` are ignored.
- R3: The data credit is `{pkt_b2[3:0], pkt_b3}`.
- R4: An accepted init packet of either phase stores both credits for its class. It sets `hdr_inf[c]` when the header credit is zero and clears it otherwise, and does the same for `dat_inf[c]` with the data credit.
- R5: An accepted update whose header credit is non-zero while `hdr_inf[c]` is set raises `fc_err` for one cycle and leaves that class's limits unchanged.
- R6: An accepted update whose data credit is non-zero while `dat_inf[c]` is set raises `fc_err` for one cycle and leaves that class's limits unchanged.
- R7: Any other accepted update overwrites both limits of its class. This includes zero credits sent while a class is infinite. An update leaves the infinite flags unchanged.
- R8: A packet presented with `crc_ok` low or `bad_end` high changes no output.
- R9: A packet whose type has low bits 11 or high bits 00 changes no output.
- R10: `ph1_done` is set by the first accepted phase-1 init packet that completes the set of all three classes. It stays set until reset.
- R11: `ph2_done` is set by an accepted phase-2 init packet or update only when `ph1_done` was already set before that packet. Before that, such packets do not set it. It stays set until reset.
- R12: Reset, which is synchronous and active high, clears all limits, flags and `fc_err`. `fc_err` is high only in the cycle after a violating packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_vld | input | 1 | Packet bytes valid this cycle |
| pkt_b0 | input | 8 | Byte 0: type in upper nibble |
| pkt_b1 | input | 8 | Byte 1: header credit high six bits |
| pkt_b2 | input | 8 | Byte 2: header credit low bits and data credit high nibble |
| pkt_b3 | input | 8 | Byte 3: data credit low byte |
| crc_ok | input | 1 | Upstream integrity check passed |
| bad_end | input | 1 | Packet ended with a bad-end marker |
| hdr_lim | output | 24 | Header credit limits, 8 bits per class |
| dat_lim | output | 36 | Data credit limits, 12 bits per class |
| hdr_inf | output | 3 | Header infinite flag per class |
| dat_inf | output | 3 | Data infinite flag per class |
| ph1_done | output | 1 | Init phase one complete |
| ph2_done | output | 1 | Init phase two complete |
| fc_err | output | 1 | Flow-control protocol violation pulse |

## Verification
The properties assume that `crc_ok`, `bad_end` and the packet bytes are defined whenever `pkt_vld` is high. They also assume that inputs change only between sampling edges, so that a `$past` of the inputs is the packet that produced the current outputs. The stimulus drives every input from time zero and changes it only on the falling clock edge. It holds `pkt_vld` low between packets where the error pulse width is checked. It fills the unused byte bits with non-zero patterns, so that a wrong field slice shows up at the outputs.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int HDR_BITS = 8;
  localparam int DAT_BITS = 12;
  localparam int NUM_CLS  = 3;

  typedef enum logic [1:0] {
    K_NONE  = 2'b00,
    K_INIT1 = 2'b01,
    K_UPD   = 2'b10,
    K_INIT2 = 2'b11
  } fc_kind_e;

  typedef struct packed {
    logic                ok;
    fc_kind_e            kind;
    logic [1:0]          cls;
    logic [HDR_BITS-1:0] hdr;
    logic [DAT_BITS-1:0] dat;
  } fc_pkt_t;
endpackage

// File: rtl/fcr_decode.sv
module fcr_decode
  import fcr_pkg::*;
(
  input  logic       pkt_vld,
  input  logic [7:0] pkt_b0,
  input  logic [7:0] pkt_b1,
  input  logic [7:0] pkt_b2,
  input  logic [7:0] pkt_b3,
  input  logic       crc_ok,
  input  logic       bad_end,
  output fc_pkt_t    pkt
);
  logic [3:0] ty;
  logic       unused_bits;

  assign ty          = pkt_b0[7:4];
  assign unused_bits = ^{pkt_b0[3:0], pkt_b1[7:6], pkt_b2[5:4]};

  always_comb begin
    pkt.cls  = ty[1:0];
    pkt.hdr  = {pkt_b1[5:0], pkt_b2[7:6]};
    pkt.dat  = {pkt_b2[3:0], pkt_b3};
    pkt.kind = K_NONE;
    if (ty[1:0] != 2'b11) begin
      case (ty[3:2])
        2'b01:   pkt.kind = K_INIT1;
        2'b10:   pkt.kind = K_UPD;
        2'b11:   pkt.kind = K_INIT2;
        default: pkt.kind = K_NONE;
      endcase
    end
    pkt.ok = pkt_vld && crc_ok && !bad_end && (pkt.kind != K_NONE);
  end
endmodule

// File: rtl/fcr_credit_slot.sv
module fcr_credit_slot
  import fcr_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  fc_pkt_t             pkt,
  output logic [HDR_BITS-1:0] hdr_lim,
  output logic [DAT_BITS-1:0] dat_lim,
  output logic                hdr_inf,
  output logic                dat_inf,
  output logic                viol
);
  localparam logic [1:0] MY_CLS = 2'(IDX);

  logic hit, is_init, is_upd, hdr_zero, dat_zero;

  assign hit      = pkt.ok && (pkt.cls == MY_CLS);
  assign is_init  = (pkt.kind == K_INIT1) || (pkt.kind == K_INIT2);
  assign is_upd   = (pkt.kind == K_UPD);
  assign hdr_zero = (pkt.hdr == '0);
  assign dat_zero = (pkt.dat == '0);
  assign viol     = hit && is_upd &&
                    ((!hdr_zero && hdr_inf) || (!dat_zero && dat_inf));

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_lim <= '0;
      dat_lim <= '0;
      hdr_inf <= 1'b0;
      dat_inf <= 1'b0;
    end else if (hit) begin
      if (is_init) begin
        hdr_lim <= pkt.hdr;
        dat_lim <= pkt.dat;
        hdr_inf <= hdr_zero;
        dat_inf <= dat_zero;
      end else if (is_upd && !viol) begin
        hdr_lim <= pkt.hdr;
        dat_lim <= pkt.dat;
      end
    end
  end
endmodule

// File: rtl/fcr_phase_track.sv
module fcr_phase_track
  import fcr_pkg::*;
#(
  parameter int NCLS = NUM_CLS
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ok,
  input  fc_kind_e   kind,
  input  logic [1:0] cls,
  output logic       ph1_done,
  output logic       ph2_done
);
  logic [NCLS-1:0] seen, seen_nxt;
  logic            ph2_hit;

  always_comb begin
    seen_nxt = seen;
    for (int i = 0; i < NCLS; i++) begin
      if (ok && (kind == K_INIT1) && (cls == 2'(i)))
        seen_nxt[i] = 1'b1;
    end
  end

  assign ph2_hit = ok && ph1_done && ((kind == K_INIT2) || (kind == K_UPD));

  always_ff @(posedge clk) begin
    if (rst) begin
      seen     <= '0;
      ph1_done <= 1'b0;
      ph2_done <= 1'b0;
    end else begin
      seen     <= seen_nxt;
      ph1_done <= ph1_done | (&seen_nxt);
      ph2_done <= ph2_done | ph2_hit;
    end
  end
endmodule

// File: rtl/fc_credit_rx.sv
module fc_credit_rx
  import fcr_pkg::*;
#(
  parameter int NCLS  = NUM_CLS,
  parameter int HDR_W = HDR_BITS,
  parameter int DAT_W = DAT_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pkt_vld,
  input  logic [7:0]            pkt_b0,
  input  logic [7:0]            pkt_b1,
  input  logic [7:0]            pkt_b2,
  input  logic [7:0]            pkt_b3,
  input  logic                  crc_ok,
  input  logic                  bad_end,
  output logic [NCLS*HDR_W-1:0] hdr_lim,
  output logic [NCLS*DAT_W-1:0] dat_lim,
  output logic [NCLS-1:0]       hdr_inf,
  output logic [NCLS-1:0]       dat_inf,
  output logic                  ph1_done,
  output logic                  ph2_done,
  output logic                  fc_err
);
  fc_pkt_t         pkt;
  logic [NCLS-1:0] viol_vec;

  fcr_decode u_dec (
    .pkt_vld (pkt_vld),
    .pkt_b0  (pkt_b0),
    .pkt_b1  (pkt_b1),
    .pkt_b2  (pkt_b2),
    .pkt_b3  (pkt_b3),
    .crc_ok  (crc_ok),
    .bad_end (bad_end),
    .pkt     (pkt)
  );

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    fcr_credit_slot #(.IDX(g)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .pkt     (pkt),
      .hdr_lim (hdr_lim[g*HDR_W +: HDR_W]),
      .dat_lim (dat_lim[g*DAT_W +: DAT_W]),
      .hdr_inf (hdr_inf[g]),
      .dat_inf (dat_inf[g]),
      .viol    (viol_vec[g])
    );
  end

  fcr_phase_track #(.NCLS(NCLS)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .ok       (pkt.ok),
    .kind     (pkt.kind),
    .cls      (pkt.cls),
    .ph1_done (ph1_done),
    .ph2_done (ph2_done)
  );

  always_ff @(posedge clk) begin
    if (rst) fc_err <= 1'b0;
    else     fc_err <= |viol_vec;
  end
endmodule

// File: rtl/fc_credit_rx_chk.sv
module fc_credit_rx_chk (
  input logic        clk,
  input logic        rst,
  input logic        pkt_vld,
  input logic [7:0]  pkt_b0,
  input logic        crc_ok,
  input logic        bad_end,
  input logic [23:0] hdr_lim,
  input logic [35:0] dat_lim,
  input logic [2:0]  hdr_inf,
  input logic [2:0]  dat_inf,
  input logic        ph1_done,
  input logic        ph2_done,
  input logic        fc_err
);
  // R8
  discard_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_vld && (!crc_ok || bad_end)) |=>
      ($stable(hdr_lim) && $stable(dat_lim) && $stable(hdr_inf) &&
       $stable(dat_inf) && $stable(ph1_done) && $stable(ph2_done) && !fc_err));

  // R9
  unknown_type_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_vld && (pkt_b0[5:4] == 2'b11 || pkt_b0[7:6] == 2'b00)) |=>
      ($stable(hdr_lim) && $stable(dat_lim) && $stable(hdr_inf) &&
       $stable(dat_inf) && !fc_err));

  // R5
  err_source_chk: assert property (@(posedge clk) disable iff (rst)
    fc_err |-> $past(pkt_vld && crc_ok && !bad_end &&
                     pkt_b0[7:6] == 2'b10 && pkt_b0[5:4] != 2'b11));

  // R6
  err_no_store_chk: assert property (@(posedge clk) disable iff (rst)
    fc_err |-> ($stable(hdr_lim) && $stable(dat_lim) && $stable(hdr_inf) && $stable(dat_inf)));

  // R12
  idle_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    !pkt_vld |=> !fc_err);

  // R10
  ph1_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ph1_done |=> ph1_done);

  // R10
  ph1_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ph1_done) |-> $past(pkt_vld && crc_ok && !bad_end && pkt_b0[7:6] == 2'b01));

  // R11
  ph2_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ph2_done) |-> $past(ph1_done));

  // R11
  ph2_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ph2_done |=> ph2_done);
endmodule

bind fc_credit_rx fc_credit_rx_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pkt_vld  (pkt_vld),
  .pkt_b0   (pkt_b0),
  .crc_ok   (crc_ok),
  .bad_end  (bad_end),
  .hdr_lim  (hdr_lim),
  .dat_lim  (dat_lim),
  .hdr_inf  (hdr_inf),
  .dat_inf  (dat_inf),
  .ph1_done (ph1_done),
  .ph2_done (ph2_done),
  .fc_err   (fc_err)
);

// File: tb/fc_credit_rx_test.sv
`timescale 1ns/1ps
module fc_credit_rx_test;
  localparam int OBS_W = 24 + 36 + 3 + 3 + 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pkt_vld = 1'b0;
  logic [7:0]  pkt_b0 = '0, pkt_b1 = '0, pkt_b2 = '0, pkt_b3 = '0;
  logic        crc_ok = 1'b0, bad_end = 1'b0;
  logic [23:0] hdr_lim;
  logic [35:0] dat_lim;
  logic [2:0]  hdr_inf, dat_inf;
  logic        ph1_done, ph2_done, fc_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [OBS_W-1:0] exp_q[$];
  string            tag_q[$];

  logic [7:0]  m_h [3];
  logic [11:0] m_d [3];
  logic [2:0]  m_hi, m_di, m_seen;
  logic        m_p1, m_p2, m_err;

  always #2.5 clk = ~clk;

  fc_credit_rx uut (
    .clk(clk), .rst(rst), .pkt_vld(pkt_vld),
    .pkt_b0(pkt_b0), .pkt_b1(pkt_b1), .pkt_b2(pkt_b2), .pkt_b3(pkt_b3),
    .crc_ok(crc_ok), .bad_end(bad_end),
    .hdr_lim(hdr_lim), .dat_lim(dat_lim), .hdr_inf(hdr_inf), .dat_inf(dat_inf),
    .ph1_done(ph1_done), .ph2_done(ph2_done), .fc_err(fc_err)
  );

  function automatic logic [OBS_W-1:0] model_vec();
    return {m_h[2], m_h[1], m_h[0], m_d[2], m_d[1], m_d[0],
            m_hi, m_di, m_p1, m_p2, m_err};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin m_h[i] = '0; m_d[i] = '0; end
    m_hi = '0; m_di = '0; m_seen = '0; m_p1 = 1'b0; m_p2 = 1'b0; m_err = 1'b0;
  endtask

  // Scoreboard monitor: compares one expected item per cycle after the edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [OBS_W-1:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {hdr_lim, dat_lim, hdr_inf, dat_inf, ph1_done, ph2_done, fc_err};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic idle(input string tag);
    @(negedge clk);
    pkt_vld = 1'b0;
    @(posedge clk);
    m_err = 1'b0;
    exp_q.push_back(model_vec());
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [3:0] ty, input logic [7:0] h, input logic [11:0] d,
                      input bit crc, input bit bad, input string tag);
    bit acc;
    logic [1:0] c;
    bit p2n;
    @(negedge clk);
    pkt_vld = 1'b1;
    pkt_b0  = {ty, 4'h5};
    pkt_b1  = {2'b11, h[7:2]};
    pkt_b2  = {h[1:0], 2'b10, d[11:8]};
    pkt_b3  = d[7:0];
    crc_ok  = crc;
    bad_end = bad;
    @(posedge clk);
    acc   = crc && !bad && ty[1:0] != 2'b11 && ty[3:2] != 2'b00;
    c     = ty[1:0];
    m_err = 1'b0;
    p2n   = m_p2 || (acc && m_p1 && (ty[3:2] == 2'b11 || ty[3:2] == 2'b10));
    if (acc) begin
      if (ty[2]) begin
        m_h[c] = h; m_d[c] = d;
        m_hi[c] = (h == 0); m_di[c] = (d == 0);
        if (ty[3:2] == 2'b01) m_seen[c] = 1'b1;
      end else if ((h != 0 && m_hi[c]) || (d != 0 && m_di[c])) begin
        m_err = 1'b1;
      end else begin
        m_h[c] = h; m_d[c] = d;
      end
    end
    m_p1 = m_p1 || (&m_seen);
    m_p2 = p2n;
    exp_q.push_back(model_vec());
    tag_q.push_back(tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle("R12 reset state");
    send(4'd8,  8'h10, 12'h123, 1, 0, "R7 R11 update before phase one");
    send(4'd4,  8'h00, 12'h055, 1, 0, "R1 R4 init1 posted zero header");
    send(4'd5,  8'hA5, 12'hABC, 1, 0, "R2 R3 init1 non-posted fields");
    send(4'd6,  8'h33, 12'h044, 0, 0, "R8 crc mismatch discarded");
    send(4'd6,  8'h33, 12'h044, 1, 1, "R8 bad end discarded");
    send(4'd7,  8'h44, 12'h777, 1, 0, "R9 unknown type 7");
    send(4'd11, 8'h44, 12'h777, 1, 0, "R9 unknown type 11");
    send(4'd1,  8'h44, 12'h777, 1, 0, "R9 unknown type 1");
    send(4'd8,  8'h05, 12'h000, 1, 0, "R5 finite header over infinite");
    idle("R12 error pulse ends");
    send(4'd8,  8'h00, 12'h200, 1, 0, "R7 legal update posted");
    send(4'd6,  8'h03, 12'h000, 1, 0, "R10 R4 init1 completion ends phase one");
    send(4'd10, 8'h03, 12'h001, 1, 0, "R6 R11 finite data over infinite");
    send(4'd10, 8'h07, 12'h000, 1, 0, "R7 header update while data infinite");
    send(4'd13, 8'h00, 12'h000, 1, 0, "R4 init2 non-posted both infinite");
    send(4'd12, 8'h07, 12'h009, 1, 0, "R4 init2 posted clears infinite");
    send(4'd9,  8'h00, 12'h000, 1, 0, "R7 zero update on infinite class");
    send(4'd9,  8'h01, 12'h000, 1, 0, "R5 second violation");
    send(4'd9,  8'h00, 12'h010, 1, 0, "R6 back to back violation");
    idle("R12 idle after violations");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 1'b0;
    idle("R12 state after second reset");
    send(4'd12, 8'h02, 12'h002, 1, 0, "R11 init2 without phase one");
    idle("R11 phase two still clear");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule